// File: doc/BRIEF.md
# Private Countdown Timer

This block is a 32-bit countdown timer. Software reaches it through a small word-addressed register port, and it drives one level interrupt. A prescale divider sits in front of the counter. It turns a stream of `tick_en` pulses into counter steps, one step every (prescale + 1) pulses. The counter then runs either once, stopping when it expires, or forever, reloading from the load register on each expiry. Each expiry sets a sticky status bit. Software clears that bit by writing one to it. The interrupt line is that bit masked by an enable.

The control flow lives in a two-state machine. In `CT_IDLE` the counter is frozen. In `CT_RUN` it counts. The machine moves between the two states on these events:

- **`START`** (IDLE to RUN): a register write that leaves the timer enabled and has either a nonzero prescale or a nonzero count.
- **`HALT`** (RUN to IDLE): any of these:
  - a control write that changes the enable or mode bits;
  - a write of zero to load or counter while the prescale is zero;
  - a one-shot expiry;
  - a periodic expiry with a zero load and a zero prescale.
- **`HOLD`**: every other cycle keeps the current state.

A write to the load, counter or control register takes priority over a counter step in the same cycle. Such a write also restarts the prescale phase.

Top module: `pcore_cdtimer`

## Requirements
- R1: After reset the load, count, control and status registers all read zero, `irq` is low, and the counter does not move on ticks.
- R2: Registers sit at byte offsets 0x0 (load), 0x4 (count), 0x8 (control) and 0xC (status). `rdata` shows the selected register in the same cycle as `rd_en`. It reads zero when `rd_en` is low, when the offset is unaligned, or when the offset is outside these four. Writes to any other offset change nothing. Control holds bit 0 enable, bit 1 periodic mode, bit 2 interrupt enable and bits 15:8 prescale; its other bits read zero. Status holds its flag in bit 0.
- R3: While running, the counter steps once on every (prescale + 1)-th `tick_en` pulse. The prescale phase starts from zero after each load, count or control write.
- R4: A step with a nonzero count decrements it. A step with a count of zero is an expiry and sets the status flag. In one-shot mode the timer then stops with the count at zero.
- R5: On a periodic expiry the count reloads from the load register and counting continues. The exception is a zero load together with a zero prescale: the timer then stops after that single expiry.
- R6: A load write sets both load and count to the written value. If the timer is enabled, the write starts it. The exception is a zero value with a zero prescale: the timer then stops and no flag is raised.
- R7: A count write sets the count. If the timer is enabled in periodic mode with a zero prescale and the value is zero, the count takes the load value instead. If the timer is enabled, the prescale is zero and the resulting count is zero, it stops without a flag. Otherwise an enabled timer runs.
- R8: A control write that changes bit 0 or bit 1 stops counting. If the new value has bit 0 set, the timer first reloads the count from load when periodic mode is selected and the count is zero. It then runs if the new prescale is nonzero or the count is nonzero.
- R9: `irq` is high exactly when the status flag is set and control bit 2 is set.
- R10: A status write clears the flag when written bit 0 is one and leaves it alone when it is zero. An expiry in the same cycle wins over the clear.
- R11: When a load, count or control write coincides with a counter step, the write's result is what remains. The step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler input pulse |
| addr | input | ADDR_W (6) | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- the counter only runs while enabled;
- a step without a write decrements by exactly one;
- the count holds steady when there is neither a step nor a write;
- a one-shot expiry leaves the counter stopped at zero;
- a periodic expiry reloads from load;
- the status flag stays set until it is cleared;
- the prescale phase never passes the prescale value;
- `irq` only rises when it is enabled.

Some rules depend on a chain of writes and ticks, and only the bench's scenarios can show them. These are the zero-write stop rules, the single expiry with a zero load and zero prescale, the reload on enabling periodic mode, write-over-step priority, and dead offsets. A randomized stretch compares every read and every `irq` value against a cycle model built from the requirements.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int CDT_PRE_W   = 8;
    localparam int CDT_PRE_LSB = 8;

    typedef enum logic {
        CT_IDLE = 1'b0,
        CT_RUN  = 1'b1
    } cdt_state_e;

    typedef enum logic [1:0] {
        RG_LOAD  = 2'd0,
        RG_COUNT = 2'd1,
        RG_CTRL  = 2'd2,
        RG_STAT  = 2'd3
    } cdt_reg_e;

    typedef struct packed {
        logic [CDT_PRE_W-1:0] presc;
        logic                 irq_en;
        logic                 reload;
        logic                 enable;
    } cdt_ctrl_t;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
#(
    parameter int PRE_W = CDT_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] presc,
    output logic             step
);
    logic [PRE_W-1:0] phase_q;
    logic             at_term;

    assign at_term = (phase_q == presc);
    assign step    = run && tick_en && !clear && at_term;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear || !run) begin
            phase_q <= '0;
        end else if (tick_en) begin
            phase_q <= at_term ? '0 : phase_q + 1'b1;
        end
    end

    // R3: the divider phase never passes the programmed prescale
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= presc);

    // R3: a step restarts the phase
    a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> phase_q == '0);
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr_load,
    input  logic             wr_cnt,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] load_cur,
    input  logic             cur_en,
    input  logic             cur_reload,
    input  logic             cur_pre_zero,
    input  logic             new_en,
    input  logic             new_reload,
    input  logic             new_pre_zero,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    cdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             exp_d;
    logic [CNT_W-1:0] cnt_v;
    cdt_state_e       base_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        exp_d   = 1'b0;
        cnt_v   = wval;
        base_st = state_q;
        if (wr_load) begin
            cnt_d = wval;
            if (cur_en) begin
                state_d = (cur_pre_zero && wval == '0) ? CT_IDLE : CT_RUN;
            end
        end else if (wr_cnt) begin
            if (cur_en && cur_reload && cur_pre_zero && wval == '0) begin
                cnt_v = load_cur;
            end
            cnt_d = cnt_v;
            if (cur_en) begin
                state_d = (cur_pre_zero && cnt_v == '0) ? CT_IDLE : CT_RUN;
            end
        end else if (wr_ctl) begin
            if (cur_en != new_en || cur_reload != new_reload) begin
                base_st = CT_IDLE;
            end
            state_d = base_st;
            if (new_en) begin
                cnt_v = (new_reload && cnt_q == '0) ? load_cur : cnt_q;
                cnt_d = cnt_v;
                if (!new_pre_zero || cnt_v != '0) begin
                    state_d = CT_RUN;
                end
            end
        end else if (step && state_q == CT_RUN) begin
            if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end else begin
                exp_d = 1'b1;
                if (cur_reload) begin
                    cnt_d = load_cur;
                    if (load_cur == '0 && cur_pre_zero) begin
                        state_d = CT_IDLE;
                    end
                end else begin
                    state_d = CT_IDLE;
                end
            end
        end
    end

    assign count   = cnt_q;
    assign running = (state_q == CT_RUN);
    assign expire  = exp_d;

    // R8: counting only while enabled
    a_r8_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cur_en);

    // R4: a plain step decrements by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R4: one-shot expiry stops at zero
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cur_reload) |=> (!running && cnt_q == '0));

    // R5: periodic expiry reloads
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cur_reload) |=> cnt_q == $past(load_cur));

    // R11: without step or write the count holds
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_load && !wr_cnt && !wr_ctl) |=> $stable(cnt_q));
endmodule

// File: rtl/pcore_cdtimer.sv
module pcore_cdtimer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int SEL_LSB = 2;
    localparam int HI_LSB  = 4;

    cdt_ctrl_t         ctrl_q, ctrl_new;
    logic [DATA_W-1:0] load_q;
    logic              stat_q;
    logic              addr_ok;
    cdt_reg_e          sel;
    logic              wr_load, wr_cnt, wr_ctl, wr_stat, wr_any;
    logic              step, running, expire;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] ctrl_rd;

    assign addr_ok = (addr[SEL_LSB-1:0] == '0) && (addr[ADDR_W-1:HI_LSB] == '0);
    assign sel     = cdt_reg_e'(addr[HI_LSB-1:SEL_LSB]);
    assign wr_load = wr_en && addr_ok && sel == RG_LOAD;
    assign wr_cnt  = wr_en && addr_ok && sel == RG_COUNT;
    assign wr_ctl  = wr_en && addr_ok && sel == RG_CTRL;
    assign wr_stat = wr_en && addr_ok && sel == RG_STAT;
    assign wr_any  = wr_load || wr_cnt || wr_ctl;

    always_comb begin
        ctrl_new.presc  = wdata[CDT_PRE_LSB +: CDT_PRE_W];
        ctrl_new.irq_en = wdata[2];
        ctrl_new.reload = wdata[1];
        ctrl_new.enable = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            stat_q <= 1'b0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_ctl)  ctrl_q <= ctrl_new;
            if (expire) begin
                stat_q <= 1'b1;
            end else if (wr_stat && wdata[0]) begin
                stat_q <= 1'b0;
            end
        end
    end

    cdt_prescale #(.PRE_W(CDT_PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (running),
        .clear   (wr_any),
        .presc   (ctrl_q.presc),
        .step    (step)
    );

    cdt_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .step         (step),
        .wr_load      (wr_load),
        .wr_cnt       (wr_cnt),
        .wr_ctl       (wr_ctl),
        .wval         (wdata),
        .load_cur     (load_q),
        .cur_en       (ctrl_q.enable),
        .cur_reload   (ctrl_q.reload),
        .cur_pre_zero (ctrl_q.presc == '0),
        .new_en       (ctrl_new.enable),
        .new_reload   (ctrl_new.reload),
        .new_pre_zero (ctrl_new.presc == '0),
        .count        (count),
        .running      (running),
        .expire       (expire)
    );

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CDT_PRE_LSB +: CDT_PRE_W] = ctrl_q.presc;
        ctrl_rd[2] = ctrl_q.irq_en;
        ctrl_rd[1] = ctrl_q.reload;
        ctrl_rd[0] = ctrl_q.enable;
    end

    always_comb begin
        rdata = '0;
        if (rd_en && addr_ok) begin
            unique case (sel)
                RG_LOAD:  rdata = load_q;
                RG_COUNT: rdata = count;
                RG_CTRL:  rdata = ctrl_rd;
                RG_STAT:  rdata = {{(DATA_W-1){1'b0}}, stat_q};
                default:  rdata = '0;
            endcase
        end
    end

    assign irq = stat_q && ctrl_q.irq_en;

    // R10: the flag is sticky until cleared by a one in bit 0
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(wr_stat && wdata[0])) |=> stat_q);

    // R10: an expiry always leaves the flag set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> stat_q);

    // R9: no interrupt while masked
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q.irq_en);

    // R6: zero load with zero prescale halts an enabled timer
    a_r6_zero_load_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && ctrl_q.enable && ctrl_q.presc == '0 && wdata == '0) |=> !running);
endmodule

// File: tb/pcore_cdtimer_test.sv
`timescale 1ns/1ps
module pcore_cdtimer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] last_rd;

    // reference model state
    logic [31:0] m_load, m_cnt;
    logic        m_en, m_per, m_ie, m_sts, m_run;
    logic [7:0]  m_pre, m_pc;

    always #10 clk = ~clk;

    pcore_cdtimer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        if (a[1:0] != 2'b0 || a[5:4] != 2'b0) return 32'h0;
        case (a[3:2])
            2'd0: return m_load;
            2'd1: return m_cnt;
            2'd2: return {16'h0, m_pre, 5'b0, m_ie, m_per, m_en};
            default: return {31'h0, m_sts};
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        if (a[1:0] != 2'b0 || a[5:4] != 2'b0) return "R2";
        case (a[3:2])
            2'd0: return "R6";
            2'd1: return "R4";
            2'd2: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic m_update(input logic w, input logic [5:0] a, input logic [31:0] d, input logic t);
        logic ok, wl, wc, wt, ws, wany, stp, ex, n_run, ne, np;
        logic [31:0] n_cnt, nv;
        logic [7:0]  n_pc, np_pre;
        ok = (a[1:0] == 2'b0) && (a[5:4] == 2'b0);
        wl = w && ok && a[3:2] == 2'd0;
        wc = w && ok && a[3:2] == 2'd1;
        wt = w && ok && a[3:2] == 2'd2;
        ws = w && ok && a[3:2] == 2'd3;
        wany = wl || wc || wt;
        stp = m_run && t && !wany && (m_pc == m_pre);
        if (wany || !m_run) n_pc = 8'h0;
        else if (t) n_pc = (m_pc == m_pre) ? 8'h0 : m_pc + 8'h1;
        else n_pc = m_pc;
        ex = 1'b0; n_run = m_run; n_cnt = m_cnt;
        ne = d[0]; np = d[1]; np_pre = d[15:8];
        if (wl) begin
            n_cnt = d;
            if (m_en) n_run = !(m_pre == 8'h0 && d == 32'h0);
        end else if (wc) begin
            nv = (m_en && m_per && m_pre == 8'h0 && d == 32'h0) ? m_load : d;
            n_cnt = nv;
            if (m_en) n_run = !(m_pre == 8'h0 && nv == 32'h0);
        end else if (wt) begin
            n_run = (m_en != ne || m_per != np) ? 1'b0 : m_run;
            if (ne) begin
                nv = (np && m_cnt == 32'h0) ? m_load : m_cnt;
                n_cnt = nv;
                if (np_pre != 8'h0 || nv != 32'h0) n_run = 1'b1;
            end
        end else if (stp) begin
            if (m_cnt != 32'h0) n_cnt = m_cnt - 32'h1;
            else begin
                ex = 1'b1;
                if (m_per) begin
                    n_cnt = m_load;
                    if (m_load == 32'h0 && m_pre == 8'h0) n_run = 1'b0;
                end else n_run = 1'b0;
            end
        end
        if (wl) m_load = d;
        if (wt) begin m_en = ne; m_per = np; m_ie = d[2]; m_pre = np_pre; end
        if (ex) m_sts = 1'b1;
        else if (ws && d[0]) m_sts = 1'b0;
        m_cnt = n_cnt; m_run = n_run; m_pc = n_pc;
    endtask

    task automatic cyc(input logic w, input logic r, input logic [5:0] a,
                       input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
        #1;
        last_rd = rdata;
        if (r) chk(tag_of(a), rdata, m_read(a));
        chk("R9", {31'h0, irq}, {31'h0, m_sts & m_ie});
        @(posedge clk);
        m_update(w, a, d, t);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 6'h0, 32'h0, 1'b1);
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        cyc(1'b0, 1'b1, a, 32'h0, 1'b0);
        chk(tag, last_rd, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20250611);
        m_load = 0; m_cnt = 0; m_en = 0; m_per = 0; m_ie = 0; m_sts = 0; m_run = 0;
        m_pre = 0; m_pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd("R1", 6'h0, 0); rd("R1", 6'h4, 0); rd("R1", 6'h8, 0); rd("R1", 6'hC, 0);
        chk("R1", {31'h0, irq}, 32'h0);
        rd("R2", 6'h10, 0);
        ticks(3); rd("R1", 6'h4, 0);

        // R6 load while disabled
        wr(6'h0, 5); rd("R6", 6'h4, 5);
        ticks(3); rd("R6", 6'h4, 5);

        // R4 one-shot expiry
        wr(6'h8, 32'h5);
        ticks(5); rd("R4", 6'h4, 0); chk("R9", {31'h0, irq}, 0);
        ticks(1); rd("R4", 6'hC, 1); chk("R9", {31'h0, irq}, 1);
        ticks(2); rd("R4", 6'h4, 0);

        // R10 write-one-to-clear
        wr(6'hC, 0); rd("R10", 6'hC, 1);
        wr(6'hC, 1); rd("R10", 6'hC, 0); chk("R10", {31'h0, irq}, 0);

        // R3/R5 periodic with prescale 2
        wr(6'h8, 0); wr(6'h0, 2); wr(6'h8, 32'h203);
        ticks(2); rd("R3", 6'h4, 2);
        ticks(1); rd("R3", 6'h4, 1);
        ticks(5); rd("R5", 6'h4, 0); rd("R5", 6'hC, 0);
        ticks(1); rd("R5", 6'h4, 2); rd("R5", 6'hC, 1);
        chk("R9", {31'h0, irq}, 0);

        // R5 zero load, zero prescale: single expiry
        wr(6'hC, 1); wr(6'h8, 0); wr(6'h0, 0); wr(6'h4, 2); wr(6'h8, 32'h3);
        ticks(3); rd("R5", 6'hC, 1); rd("R5", 6'h4, 0);
        wr(6'hC, 1); ticks(3); rd("R5", 6'hC, 0);

        // R5 zero load, nonzero prescale: keeps expiring
        wr(6'h8, 0); wr(6'h4, 1); wr(6'h8, 32'h103);
        ticks(4); rd("R5", 6'hC, 1);
        wr(6'hC, 1); ticks(2); rd("R5", 6'hC, 1);

        // R6 zero load stops without flag
        wr(6'h8, 0); wr(6'hC, 1); wr(6'h0, 7); wr(6'h8, 32'h1);
        ticks(1); rd("R6", 6'h4, 6);
        wr(6'h0, 0); ticks(3); rd("R6", 6'hC, 0); rd("R6", 6'h4, 0);

        // R7 periodic zero count write takes load
        wr(6'h8, 0); wr(6'h0, 4); wr(6'h8, 32'h3);
        ticks(1); rd("R7", 6'h4, 3);
        wr(6'h4, 0); rd("R7", 6'h4, 4);
        ticks(1); rd("R7", 6'h4, 3);

        // R7 one-shot zero count write stops without flag
        wr(6'h8, 0); wr(6'h8, 32'h1);
        wr(6'h4, 0); ticks(3); rd("R7", 6'hC, 0); rd("R7", 6'h4, 0);

        // R8 mode change halts, re-enable restarts
        wr(6'h4, 3); ticks(1); rd("R8", 6'h4, 2);
        wr(6'h8, 32'h4); ticks(3); rd("R8", 6'h4, 2);
        wr(6'h8, 32'h1); ticks(1); rd("R8", 6'h4, 1);
        // R8 enabling periodic with zero count reloads
        wr(6'h8, 0); wr(6'h0, 6); wr(6'h4, 0); wr(6'h8, 32'h3);
        rd("R8", 6'h4, 6); ticks(1); rd("R8", 6'h4, 5);

        // R11 write beats coincident step
        cyc(1'b1, 1'b0, 6'h4, 9, 1'b1); rd("R11", 6'h4, 9);

        // R2 dead offsets and reserved bits
        wr(6'h14, 32'hFFFF); rd("R2", 6'h0, 6);
        wr(6'h1, 32'h0); rd("R2", 6'h0, 6);
        wr(6'h8, 32'hFFFF_FF07); rd("R2", 6'h8, 32'h0000_FF07);
        wr(6'h8, 0); wr(6'hC, 1);

        // randomized traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic t;
            r = $urandom % 100;
            t = ($urandom % 4) != 0;
            if (r < 8)       cyc(1'b1, 1'b0, 6'h0, $urandom % 6, t);
            else if (r < 14) cyc(1'b1, 1'b0, 6'h4, $urandom % 6, t);
            else if (r < 20) cyc(1'b1, 1'b0, 6'h8,
                                 {16'h0, 8'($urandom % 3), 5'b0, 3'($urandom)}, t);
            else if (r < 26) cyc(1'b1, 1'b0, 6'hC, $urandom % 2, t);
            else if (r < 28) cyc(1'b1, 1'b0, 6'($urandom % 64) | 6'h10, $urandom, t);
            else             cyc(1'b0, 1'b1, 6'($urandom % 64), 32'h0, t);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule